// File: doc/BRIEF.md
# Frame-Pattern PWM Generator

The block makes a single PWM waveform by sending out a 64-bit frame again and again, one bit per bit period, lowest bit first. One frame is one PWM period. The frame carries a run of ones in its low-order bits, so the high time is set by how many ones the frame holds. A bit period is a whole number of master clock cycles, set by a divider input.

Software turns a requested period and duty into a divider and a duty count before it drives this block. The divider is roughly the master clock rate times the period, divided by 64. The duty count is 64 times the duty over the period, rounded to the nearest integer.

The block takes the divider, the duty count and a polarity flag into a shadow copy only at a frame boundary, so a period never mixes old and new settings. When the block is disabled, the pin rests at its inactive level.

Top module: `pfg_frame_pwm`

## Requirements
- R1: While enabled, each frame bit lasts exactly D master clock cycles, where D is the divider value. A frame of 64 bits therefore lasts 64*D cycles, and frames follow one another with no gap.
- R2: With `invert` low and duty count N, the output is high for the first N bit periods of each frame and low for the remaining 64-N. Bit 0 is sent first.
- R3: A duty count of 0 keeps the output low for the whole frame. A duty count of 64 keeps it high for the whole frame.
- R4: A duty count above 64 acts exactly as 64, which gives a constant high output with `invert` low.
- R5: With `invert` high, every bit of the frame is the complement of the bit sent with `invert` low for the same duty count.
- R6: The divider, duty count and polarity are taken at the start of a frame. A change made in the middle of a frame leaves the rest of that frame unchanged and takes effect from the next frame.
- R7: While disabled, the output holds the inactive level: low when `invert` is 0, high when `invert` is 1. It follows `invert` one cycle later. After reset the output is low.
- R8: A divider value of 0 behaves as a divider of 1.
- R9: `enable` is sampled on the clock edge. The cycle after it is seen high, the first frame starts at bit 0. The cycle after it is seen low, output stops. A later enable restarts the frame at bit 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Run the waveform when high |
| div_val | input | 8 | Master clock cycles per frame bit (0 acts as 1) |
| duty_cnt | input | 7 | Number of leading high bits per frame, 0 to 64; larger values saturate |
| invert | input | 1 | Send the complement of the frame pattern |
| pwm_out | output | 1 | PWM output pin |

## Verification
A wrong bit index or divider count shows up as a high-time edge in the wrong cycle within the first frame. A frame that runs long or short shifts every following edge. The bench compares every cycle of every frame against a model, so a single misplaced edge is caught in the frame where it happens. A shadow copy that reloads too early, mid-frame, changes the level before the boundary of the frame in which the inputs moved. A wrong idle level is visible within two cycles of the enable dropping.

// File: rtl/pfg_pkg.sv
package pfg_pkg;

    localparam int unsigned FRAME_BITS = 64;
    localparam int unsigned DIV_W      = 8;
    localparam int unsigned DUTY_W     = $clog2(FRAME_BITS + 1);
    localparam int unsigned IDX_W      = $clog2(FRAME_BITS);

    typedef struct packed {
        logic [DIV_W-1:0]  div;
        logic [DUTY_W-1:0] duty;
        logic              inv;
    } pfg_cfg_t;

    localparam pfg_cfg_t CFG_RESET = '{div: DIV_W'(1), duty: '0, inv: 1'b0};

    // Clamp the duty count to the frame length.
    function automatic logic [DUTY_W-1:0] clamp_duty(input logic [DUTY_W-1:0] d);
        return (d > DUTY_W'(FRAME_BITS)) ? DUTY_W'(FRAME_BITS) : d;
    endfunction

    // A zero divider is lifted to one.
    function automatic logic [DIV_W-1:0] floor_div(input logic [DIV_W-1:0] d);
        return (d == '0) ? DIV_W'(1) : d;
    endfunction

    function automatic pfg_cfg_t sanitize(input pfg_cfg_t raw);
        pfg_cfg_t c;
        c.div  = floor_div(raw.div);
        c.duty = clamp_duty(raw.duty);
        c.inv  = raw.inv;
        return c;
    endfunction

endpackage

// File: rtl/pfg_shadow.sv
module pfg_shadow
    import pfg_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     load,
    input  pfg_cfg_t cfg_in,
    output pfg_cfg_t cfg_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= CFG_RESET;
        end else if (load) begin
            cfg_q <= cfg_in;
        end
    end

endmodule

// File: rtl/pfg_bitclk.sv
module pfg_bitclk
    import pfg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             bit_tick,
    output logic             frame_end,
    output logic [IDX_W-1:0] bit_idx,
    output logic [DIV_W-1:0] div_cnt
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);

    logic last_cycle;

    assign last_cycle = (div_cnt == (div - DIV_W'(1)));
    assign bit_tick   = run && last_cycle;
    assign frame_end  = bit_tick && (bit_idx == LAST_IDX);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            div_cnt <= '0;
            bit_idx <= '0;
        end else if (last_cycle) begin
            div_cnt <= '0;
            bit_idx <= (bit_idx == LAST_IDX) ? '0 : bit_idx + IDX_W'(1);
        end else begin
            div_cnt <= div_cnt + DIV_W'(1);
        end
    end

endmodule

// File: rtl/pfg_thermo.sv
module pfg_thermo
    import pfg_pkg::*;
(
    input  logic [DUTY_W-1:0]     duty,
    input  logic                  inv,
    output logic [FRAME_BITS-1:0] mask
);

    for (genvar i = 0; i < FRAME_BITS; i++) begin : g_bit
        assign mask[i] = (DUTY_W'(i) < duty) ^ inv;
    end

endmodule

// File: rtl/pfg_shifter.sv
module pfg_shifter
    import pfg_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  load,
    input  logic                  shift,
    input  logic [FRAME_BITS-1:0] mask_in,
    output logic                  lsb
);

    logic [FRAME_BITS-1:0] frame_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_q <= '0;
        end else if (load) begin
            frame_q <= mask_in;
        end else if (shift) begin
            frame_q <= {1'b0, frame_q[FRAME_BITS-1:1]};
        end
    end

    assign lsb = frame_q[0];

endmodule

// File: rtl/pfg_frame_pwm.sv
module pfg_frame_pwm
    import pfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic [DIV_W-1:0]  div_val,
    input  logic [DUTY_W-1:0] duty_cnt,
    input  logic              invert,
    output logic              pwm_out
);

    logic                  run_q;
    logic                  load;
    logic                  bit_tick;
    logic                  frame_end;
    logic [IDX_W-1:0]      bit_idx;
    logic [DIV_W-1:0]      div_cnt;
    logic [FRAME_BITS-1:0] mask;
    logic                  frame_lsb;
    pfg_cfg_t              raw_cfg;
    pfg_cfg_t              next_cfg;
    pfg_cfg_t              act_cfg;
    logic [DUTY_W-1:0]     act_duty;
    logic [DIV_W-1:0]      act_div;
    logic                  act_inv;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= 1'b0;
        end else begin
            run_q <= enable;
        end
    end

    assign raw_cfg  = '{div: div_val, duty: duty_cnt, inv: invert};
    assign next_cfg = sanitize(raw_cfg);
    // Settings follow the inputs while idle; while running only at a frame boundary.
    assign load     = !run_q || frame_end;

    pfg_shadow u_shadow (
        .clk    (clk),
        .rst    (rst),
        .load   (load),
        .cfg_in (next_cfg),
        .cfg_q  (act_cfg)
    );

    assign act_duty = act_cfg.duty;
    assign act_div  = act_cfg.div;
    assign act_inv  = act_cfg.inv;

    pfg_bitclk u_bitclk (
        .clk       (clk),
        .rst       (rst),
        .run       (run_q),
        .div       (act_div),
        .bit_tick  (bit_tick),
        .frame_end (frame_end),
        .bit_idx   (bit_idx),
        .div_cnt   (div_cnt)
    );

    pfg_thermo u_thermo (
        .duty (next_cfg.duty),
        .inv  (next_cfg.inv),
        .mask (mask)
    );

    pfg_shifter u_shifter (
        .clk     (clk),
        .rst     (rst),
        .load    (load),
        .shift   (bit_tick),
        .mask_in (mask),
        .lsb     (frame_lsb)
    );

    assign pwm_out = run_q ? frame_lsb : act_inv;

endmodule

// File: rtl/pfg_frame_pwm_chk.sv
module pfg_frame_pwm_chk
    import pfg_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              enable,
    input logic              invert,
    input logic              pwm_out,
    input logic              run_q,
    input logic              bit_tick,
    input logic              frame_end,
    input logic [IDX_W-1:0]  bit_idx,
    input logic [DIV_W-1:0]  div_cnt,
    input logic [DUTY_W-1:0] act_duty,
    input logic [DIV_W-1:0]  act_div,
    input logic              act_inv
);

    assert_bit_hold_R1: assert property (@(posedge clk) disable iff (rst)
        (run_q && $past(run_q) && !$past(bit_tick)) |-> $stable(pwm_out));

    assert_frame_start_R2: assert property (@(posedge clk) disable iff (rst)
        (run_q && bit_idx == '0 && act_duty != '0) |-> (pwm_out == !act_inv));

    assert_wrap_R2: assert property (@(posedge clk) disable iff (rst)
        frame_end |=> (bit_idx == '0));

    assert_duty_sat_R4: assert property (@(posedge clk) disable iff (rst)
        act_duty <= DUTY_W'(FRAME_BITS));

    assert_div_nonzero_R8: assert property (@(posedge clk) disable iff (rst)
        act_div != '0);

    assert_shadow_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (run_q && $past(run_q) && !$past(frame_end)) |->
            ($stable(act_duty) && $stable(act_div) && $stable(act_inv)));

    assert_idle_level_R7: assert property (@(posedge clk) disable iff (rst)
        (!run_q && $past(!run_q) && $past(!rst)) |-> (pwm_out == $past(invert)));

    assert_run_follow_R9: assert property (@(posedge clk) disable iff (rst)
        $past(!rst) |-> (run_q == $past(enable)));

    assert_restart_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(run_q) |-> (bit_idx == '0 && div_cnt == '0));

endmodule

bind pfg_frame_pwm pfg_frame_pwm_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .enable    (enable),
    .invert    (invert),
    .pwm_out   (pwm_out),
    .run_q     (run_q),
    .bit_tick  (bit_tick),
    .frame_end (frame_end),
    .bit_idx   (bit_idx),
    .div_cnt   (div_cnt),
    .act_duty  (act_duty),
    .act_div   (act_div),
    .act_inv   (act_inv)
);

// File: tb/pfg_frame_pwm_tb_top.sv
module pfg_frame_pwm_tb_top;
    import pfg_pkg::*;

    localparam time CLK_PERIOD = 10ns;

    logic              clk = 1'b0;
    logic              rst;
    logic              enable;
    logic [DIV_W-1:0]  div_val;
    logic [DUTY_W-1:0] duty_cnt;
    logic              invert;
    logic              pwm_out;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    pfg_frame_pwm dut_i (
        .clk      (clk),
        .rst      (rst),
        .enable   (enable),
        .div_val  (div_val),
        .duty_cnt (duty_cnt),
        .invert   (invert),
        .pwm_out  (pwm_out)
    );

    task automatic check(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic model_level(input int b, input int duty, input logic inv);
        int n;
        n = (duty > FRAME_BITS) ? FRAME_BITS : duty;
        return logic'(b < n) ^ inv;
    endfunction

    task automatic set_cfg(input int div, input int duty, input logic inv);
        div_val  = DIV_W'(div);
        duty_cnt = DUTY_W'(duty);
        invert   = inv;
    endtask

    // Stop, load settings while idle, then enable; returns at the first cycle of the frame.
    task automatic start_run(input int div, input int duty, input logic inv);
        @(negedge clk);
        enable = 1'b0;
        set_cfg(div, duty, inv);
        repeat (3) @(negedge clk);
        enable = 1'b1;
        @(negedge clk);
    endtask

    // Compare every cycle of one frame; optionally change inputs at cycle chg_at.
    task automatic check_frame(input int div, input int duty, input logic inv, input string req,
                               input int chg_at, input int ndiv, input int nduty, input logic ninv);
        int d;
        int bad;
        int first_act;
        int first_exp;
        d = (div == 0) ? 1 : div;
        bad = 0;
        first_act = 0;
        first_exp = 0;
        for (int i = 0; i < FRAME_BITS * d; i++) begin
            logic e;
            e = model_level(i / d, duty, inv);
            if (pwm_out !== e) begin
                if (bad == 0) begin
                    first_act = int'(pwm_out);
                    first_exp = int'(e);
                end
                bad++;
            end
            if (i == chg_at) set_cfg(ndiv, nduty, ninv);
            @(negedge clk);
        end
        check(bad == 0, req, first_act, first_exp);
    endtask

    task automatic t_reset;
        rst = 1'b1;
        enable = 1'b0;
        set_cfg(2, 0, 1'b0);
        repeat (4) @(negedge clk);
        check(pwm_out == 1'b0, "R7 reset level", int'(pwm_out), 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_idle;
        @(negedge clk);
        enable = 1'b0;
        invert = 1'b1;
        repeat (2) @(negedge clk);
        check(pwm_out == 1'b1, "R7 idle inverted", int'(pwm_out), 1);
        invert = 1'b0;
        repeat (2) @(negedge clk);
        check(pwm_out == 1'b0, "R7 idle normal", int'(pwm_out), 0);
    endtask

    task automatic t_basic;
        start_run(1, 20, 1'b0);
        check_frame(1, 20, 1'b0, "R2 duty 20 div 1", -1, 0, 0, 1'b0);
        start_run(3, 1, 1'b0);
        check_frame(3, 1, 1'b0, "R1 duty 1 div 3", -1, 0, 0, 1'b0);
        check_frame(3, 1, 1'b0, "R1 back-to-back frame", -1, 0, 0, 1'b0);
    endtask

    task automatic t_edges;
        start_run(2, 0, 1'b0);
        check_frame(2, 0, 1'b0, "R3 duty 0", -1, 0, 0, 1'b0);
        start_run(2, 64, 1'b0);
        check_frame(2, 64, 1'b0, "R3 duty 64", -1, 0, 0, 1'b0);
        start_run(1, 65, 1'b0);
        check_frame(1, 64, 1'b0, "R4 duty 65 saturates", -1, 0, 0, 1'b0);
        start_run(1, 127, 1'b0);
        check_frame(1, 64, 1'b0, "R4 duty 127 saturates", -1, 0, 0, 1'b0);
    endtask

    task automatic t_invert;
        start_run(2, 20, 1'b1);
        check_frame(2, 20, 1'b1, "R5 inverted duty 20", -1, 0, 0, 1'b0);
        start_run(1, 0, 1'b1);
        check_frame(1, 0, 1'b1, "R5 inverted duty 0", -1, 0, 0, 1'b0);
    endtask

    task automatic t_div_zero;
        start_run(0, 33, 1'b0);
        check_frame(1, 33, 1'b0, "R8 divider 0 as 1", -1, 0, 0, 1'b0);
    endtask

    task automatic t_shadow;
        start_run(2, 10, 1'b0);
        check_frame(2, 10, 1'b0, "R6 frame before change", 30, 3, 50, 1'b1);
        check_frame(3, 50, 1'b1, "R6 frame after change", -1, 0, 0, 1'b0);
    endtask

    task automatic t_restart;
        start_run(2, 40, 1'b1);
        repeat (17) @(negedge clk);
        enable = 1'b0;
        @(negedge clk);
        check(pwm_out == 1'b1, "R9 stop next cycle", int'(pwm_out), 1);
        @(negedge clk);
        check(pwm_out == 1'b1, "R7 idle after stop", int'(pwm_out), 1);
        enable = 1'b1;
        @(negedge clk);
        check_frame(2, 40, 1'b1, "R9 restart at bit 0", -1, 0, 0, 1'b0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_idle();
        t_basic();
        t_edges();
        t_invert();
        t_div_zero();
        t_shadow();
        t_restart();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule